// File: doc/BRIEF.md
# Raster Timing Generator with Half-Step Pixel Divider

This block drives a parallel RGB panel. A fast display clock enters the block. A fractional divider turns that clock into a one-cycle pixel strobe, and the divider can step in halves of a display-clock period. On every strobe a horizontal position counter advances. When a line ends, a vertical position counter advances. From the two positions the block decodes horizontal sync, vertical sync and data enable.

Each axis is split into five segments, which always run in this order: reference-to-sync, sync pulse, back porch, active area, front porch. The timing registers are shared between the axes. The low half of each register holds the horizontal value and the high half holds the vertical value. The usual software convention sets reference-to-sync to 1 and subtracts that 1 from the front porch it requests. The hardware uses whatever values it is given.

The block assumes every segment length is at least 1.

Top module: `raster_timing_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `pix_en`, `h_pos` and `v_pos` to 0. Position 0 falls in the reference-to-sync segment, so `hsync`, `vsync` and `de` are then 0.
- R2: With divider field D held, the strobe period is (D+2) half display-clock cycles. D=0 gives a strobe on every clock. An even D+2 gives a fixed interval of (D+2)/2 clocks.
- R3: When D+2 is odd, the intervals between strobes alternate between the floor and the ceiling of (D+2)/2. Any (D+2) consecutive clocks then hold exactly 2 strobes.
- R4: `h_pos` increments by one on each clock that follows a cycle with `pix_en` high, and holds its value otherwise. After reaching ref+sync+back+active+front−1 it returns to 0.
- R5: `v_pos` increments only in the step where `h_pos` wraps to 0, and holds its value otherwise. After reaching the vertical total minus 1 it returns to 0.
- R6: `hsync` is high exactly while `h_pos` lies in [ref, ref+sync). `vsync` is high exactly while `v_pos` lies in the same window computed from the vertical values. Both are active high.
- R7: `de` is high exactly when `h_pos` lies in [ref+sync+back, ref+sync+back+active) and `v_pos` lies in the matching vertical window. It is therefore never high together with either sync.
- R8: Packing: in each timing register, bits 15:0 hold the horizontal value and bits 31:16 hold the vertical value. In the active register, bits 15:0 hold the width and bits 31:16 hold the height.
- R9: If the line total is reduced below the current position, the next strobe returns `h_pos` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ref_sync | input | 32 | Reference-to-sync length, vertical:horizontal |
| cfg_sync_width | input | 32 | Sync pulse length, vertical:horizontal |
| cfg_back_porch | input | 32 | Back porch length, vertical:horizontal |
| cfg_front_porch | input | 32 | Front porch length, vertical:horizontal |
| cfg_active | input | 32 | Active height:width |
| cfg_pix_div | input | 8 | Divider in 7.1 format; period = (value+2)/2 clocks |
| pix_en | output | 1 | One-cycle pixel strobe |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable |
| h_pos | output | 19 | Position within the line |
| v_pos | output | 19 | Line position within the frame |

## Verification
`pix_en`, `h_pos` and `v_pos` are registers, so each one shows the effect of a clock edge straight after that edge. A strobe that is visible in one cycle therefore moves the counters at the following edge. `hsync`, `vsync` and `de` are decoded from the counters and the configuration without any further register. They are valid in the same cycle as the positions.

The bench keeps a behavioural model that steps at each rising edge. It drives inputs shortly after the rising edge and compares every output at the falling edge. This keeps every sample one full register stage behind its cause. The strobe-count checks wait a few clocks after each divider change, so that only the settled pattern is counted.

// File: rtl/raster_pkg.sv
// Shared definitions for the raster timing generator.
// Assumes segments are visited in the fixed order listed in seg_e.
package raster_pkg;
    typedef enum logic [2:0] {
        SEG_REF   = 3'd0,
        SEG_SYNC  = 3'd1,
        SEG_BACK  = 3'd2,
        SEG_ACT   = 3'd3,
        SEG_FRONT = 3'd4
    } seg_e;
endpackage

// File: rtl/raster_pix_div.sv
// Pixel strobe divider with half-cycle resolution.
// The divider field is 7.1 fixed point; the strobe period is (field+2) half clocks.
// Every clock adds two half units to an accumulator. A strobe fires when the
// accumulator reaches the period, and the period is then subtracted from it.
// Assumes the field may change at any time; the accumulator settles on its own.
module raster_pix_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_field,
    output logic             strobe
);
    localparam int ACC_W = DIV_W + 2;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] period;
    logic [ACC_W-1:0] nxt;
    logic             hit;

    // Period in half units and the accumulator value for the next clock.
    always_comb begin
        period = ACC_W'(div_field) + ACC_W'(2);
        nxt    = acc + ACC_W'(2);
        hit    = (nxt >= period);
    end

    // Accumulator and registered strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc    <= '0;
            strobe <= 1'b0;
        end else begin
            acc    <= hit ? (nxt - period) : nxt;
            strobe <= hit;
        end
    end
endmodule

// File: rtl/raster_axis.sv
// One axis of the raster: a position counter that moves through five segments.
// The counter advances on step and wraps after the last front-porch position.
// Assumes every segment length is at least 1.
module raster_axis
    import raster_pkg::*;
#(
    parameter int W = 16,
    localparam int SW = W + 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [W-1:0]  len_ref,
    input  logic [W-1:0]  len_sync,
    input  logic [W-1:0]  len_back,
    input  logic [W-1:0]  len_act,
    input  logic [W-1:0]  len_front,
    output logic [SW-1:0] pos,
    output seg_e          seg,
    output logic          wrap
);
    logic [SW-1:0] end_ref, end_sync, end_back, end_act, end_total;
    logic          at_last;

    // Segment boundaries as cumulative end positions.
    always_comb begin
        end_ref   = SW'(len_ref);
        end_sync  = end_ref  + SW'(len_sync);
        end_back  = end_sync + SW'(len_back);
        end_act   = end_back + SW'(len_act);
        end_total = end_act  + SW'(len_front);
    end

    // Segment decode from the current position.
    always_comb begin
        if (pos < end_ref)       seg = SEG_REF;
        else if (pos < end_sync) seg = SEG_SYNC;
        else if (pos < end_back) seg = SEG_BACK;
        else if (pos < end_act)  seg = SEG_ACT;
        else                     seg = SEG_FRONT;
    end

    // End-of-axis detection; >= also recovers when the total shrinks.
    always_comb begin
        at_last = (pos >= end_total - SW'(1));
        wrap    = step && at_last;
    end

    // Position counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    pos <= '0;
        else if (step) pos <= at_last ? '0 : pos + SW'(1);
    end
endmodule

// File: rtl/raster_timing_gen.sv
// Raster timing generator top level.
// Splits the packed registers (horizontal in the low half, vertical in the high
// half), runs the pixel divider and one counter per axis, and decodes sync and DE.
// Assumes the configuration inputs are static or change only between checks.
module raster_timing_gen
    import raster_pkg::*;
#(
    parameter int AXIS_W = 16,
    parameter int DIV_W  = 8,
    localparam int REG_W = 2 * AXIS_W,
    localparam int POS_W = AXIS_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] cfg_ref_sync,
    input  logic [REG_W-1:0] cfg_sync_width,
    input  logic [REG_W-1:0] cfg_back_porch,
    input  logic [REG_W-1:0] cfg_front_porch,
    input  logic [REG_W-1:0] cfg_active,
    input  logic [DIV_W-1:0] cfg_pix_div,
    output logic             pix_en,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic [POS_W-1:0] h_pos,
    output logic [POS_W-1:0] v_pos
);
    localparam int N_AX = 2;

    seg_e             seg    [N_AX];
    logic [POS_W-1:0] pos    [N_AX];
    logic             wrap   [N_AX];
    logic             step   [N_AX];

    // Pixel strobe generation.
    raster_pix_div #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_field (cfg_pix_div),
        .strobe    (pix_en)
    );

    // Axis 0 steps on each strobe; axis 1 steps when axis 0 wraps.
    always_comb begin
        step[0] = pix_en;
        step[1] = wrap[0];
    end

    // One counter per axis, each taking its own half of the packed registers.
    for (genvar a = 0; a < N_AX; a++) begin : g_axis
        raster_axis #(.W(AXIS_W)) u_axis (
            .clk       (clk),
            .rst_n     (rst_n),
            .step      (step[a]),
            .len_ref   (cfg_ref_sync   [a*AXIS_W +: AXIS_W]),
            .len_sync  (cfg_sync_width [a*AXIS_W +: AXIS_W]),
            .len_back  (cfg_back_porch [a*AXIS_W +: AXIS_W]),
            .len_act   (cfg_active     [a*AXIS_W +: AXIS_W]),
            .len_front (cfg_front_porch[a*AXIS_W +: AXIS_W]),
            .pos       (pos[a]),
            .seg       (seg[a]),
            .wrap      (wrap[a])
        );
    end

    // Output decode.
    always_comb begin
        h_pos = pos[0];
        v_pos = pos[1];
        hsync = (seg[0] == SEG_SYNC);
        vsync = (seg[1] == SEG_SYNC);
        de    = (seg[0] == SEG_ACT) && (seg[1] == SEG_ACT);
    end
endmodule

// File: rtl/raster_timing_chk.sv
// Assertion checker for raster_timing_gen, attached through bind.
// Assumes synchronous active-low reset; every property is disabled while reset is low.
module raster_timing_chk #(
    parameter int AXIS_W = 16,
    parameter int DIV_W  = 8,
    localparam int POS_W = AXIS_W + 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] cfg_pix_div,
    input logic             pix_en,
    input logic             hsync,
    input logic             vsync,
    input logic             de,
    input logic [POS_W-1:0] h_pos,
    input logic [POS_W-1:0] v_pos
);
    // Reset clears the strobe and both counters.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!pix_en && h_pos == '0 && v_pos == '0));

    // With a divider of two or more whole clocks, strobes never come back to back.
    assert_no_double_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && cfg_pix_div >= DIV_W'(2) && $stable(cfg_pix_div)) |=> !pix_en);

    // A half-step divider of 1.5 never leaves two idle cycles in a row.
    assert_half_step_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_en && cfg_pix_div == DIV_W'(1) && $past(cfg_pix_div) == DIV_W'(1)
         && $past(rst_n)) |=> pix_en);

    // Horizontal position holds without a strobe.
    assert_h_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> $stable(h_pos));

    // Vertical position changes only when the line wraps to 0.
    assert_v_on_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(v_pos) |-> (h_pos == '0));

    // Data enable never coincides with either sync pulse.
    assert_de_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (!hsync && !vsync));
endmodule

bind raster_timing_gen raster_timing_chk #(.AXIS_W(AXIS_W), .DIV_W(DIV_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_pix_div (cfg_pix_div),
    .pix_en      (pix_en),
    .hsync       (hsync),
    .vsync       (vsync),
    .de          (de),
    .h_pos       (h_pos),
    .v_pos       (v_pos)
);

// File: tb/raster_timing_gen_bench.sv
// Self-checking bench with a behavioural reference model compared on every clock.
module raster_timing_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_ref_sync, cfg_sync_width, cfg_back_porch, cfg_front_porch, cfg_active;
    logic [7:0]  cfg_pix_div;
    logic        pix_en, hsync, vsync, de;
    logic [18:0] h_pos, v_pos;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit compare_on = 1'b0;
    string h_tag = "R4";

    // Reference model state.
    int  m_acc = 0;
    bit  m_pix = 1'b0;
    int  m_h = 0;
    int  m_v = 0;

    raster_timing_gen u_raster_timing_gen (
        .clk(clk), .rst_n(rst_n),
        .cfg_ref_sync(cfg_ref_sync), .cfg_sync_width(cfg_sync_width),
        .cfg_back_porch(cfg_back_porch), .cfg_front_porch(cfg_front_porch),
        .cfg_active(cfg_active), .cfg_pix_div(cfg_pix_div),
        .pix_en(pix_en), .hsync(hsync), .vsync(vsync), .de(de),
        .h_pos(h_pos), .v_pos(v_pos)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Field helpers: horizontal in bits 15:0, vertical in bits 31:16 (R8).
    function automatic int fld(input logic [31:0] r, input int axis);
        return axis == 0 ? int'(r[15:0]) : int'(r[31:16]);
    endfunction

    function automatic int total(input int axis);
        return fld(cfg_ref_sync, axis) + fld(cfg_sync_width, axis) + fld(cfg_back_porch, axis)
             + fld(cfg_active, axis) + fld(cfg_front_porch, axis);
    endfunction

    function automatic bit in_sync(input int p, input int axis);
        int lo = fld(cfg_ref_sync, axis);
        return p >= lo && p < lo + fld(cfg_sync_width, axis);
    endfunction

    function automatic bit in_act(input int p, input int axis);
        int lo = fld(cfg_ref_sync, axis) + fld(cfg_sync_width, axis) + fld(cfg_back_porch, axis);
        return p >= lo && p < lo + fld(cfg_active, axis);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Model: counters move on the strobe that was visible before the edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_acc = 0; m_pix = 0; m_h = 0; m_v = 0;
        end else begin
            if (m_pix) begin
                if (m_h >= total(0) - 1) begin
                    m_h = 0;
                    m_v = (m_v >= total(1) - 1) ? 0 : m_v + 1;
                end else begin
                    m_h = m_h + 1;
                end
            end
            // Half-clock accounting: two halves per clock, period of div+2 halves.
            m_acc = m_acc + 2;
            if (m_acc >= int'(cfg_pix_div) + 2) begin
                m_acc = m_acc - (int'(cfg_pix_div) + 2);
                m_pix = 1;
            end else begin
                m_pix = 0;
            end
        end
    end

    // Per-cycle comparison, away from the rising edge.
    always @(negedge clk) begin
        if (compare_on && rst_n) begin
            check("R2/R3 pix_en", int'(pix_en), int'(m_pix));
            check(h_tag,           int'(h_pos), m_h);
            check("R5 v_pos",      int'(v_pos), m_v);
            check("R6 hsync",      int'(hsync), int'(in_sync(m_h, 0)));
            check("R6 vsync",      int'(vsync), int'(in_sync(m_v, 1)));
            check("R7/R8 de",      int'(de),    int'(in_act(m_h, 0) && in_act(m_v, 1)));
        end
    end

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        if (cycles > WATCHDOG) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected <= %0d cycles", cycles, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic count_strobes(input int n, input int exp, input string tag);
        int got = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pix_en) got++;
        end
        check(tag, got, exp);
    endtask

    task automatic set_div(input int d, input int settle);
        @(posedge clk); #2;
        cfg_pix_div = 8'(d);
        repeat (settle) @(posedge clk);
        #2;
    endtask

    initial begin
        // Horizontal 1,2,2,4,1 (total 10); vertical 1,1,1,3,2 (total 8).
        cfg_ref_sync    = {16'd1, 16'd1};
        cfg_sync_width  = {16'd1, 16'd2};
        cfg_back_porch  = {16'd1, 16'd2};
        cfg_active      = {16'd3, 16'd4};
        cfg_front_porch = {16'd2, 16'd1};
        cfg_pix_div     = 8'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state.
        check("R1 pix_en", int'(pix_en), 0);
        check("R1 h_pos",  int'(h_pos), 0);
        check("R1 v_pos",  int'(v_pos), 0);
        check("R1 hsync/de", int'(hsync | vsync | de), 0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        compare_on = 1'b1;

        // R2: divide by 1, full frames.
        repeat (4) @(posedge clk);
        #2;
        count_strobes(10, 10, "R2 div1 count");
        repeat (200) @(posedge clk);

        // R3: divide by 1.5.
        set_div(1, 4);
        count_strobes(30, 20, "R3 div1.5 count");
        repeat (300) @(posedge clk);

        // R3: divide by 2.5.
        set_div(3, 6);
        count_strobes(50, 20, "R3 div2.5 count");
        repeat (400) @(posedge clk);

        // R2: divide by 4.
        set_div(6, 8);
        count_strobes(40, 10, "R2 div4 count");
        repeat (300) @(posedge clk);

        // R9: shrink the line while the position may be past the new end.
        set_div(0, 0);
        wait (h_pos == 19'd8);
        @(posedge clk); #2;
        h_tag = "R9 h_pos shrink";
        cfg_active = {16'd3, 16'd2};
        repeat (200) @(posedge clk);
        #2;
        h_tag = "R4";

        // R1: reset mid-frame returns to the start.
        rst_n = 1'b0;
        compare_on = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 h_pos after reset", int'(h_pos), 0);
        check("R1 v_pos after reset", int'(v_pos), 0);
        check("R1 pix_en after reset", int'(pix_en), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule